// File: doc/BRIEF.md
# Flash Operation Sequencer

This block works through a packed program of flash bus steps and drives a simple parallel NAND-style interface. A host loads a 32-bit program word made of eight 4-bit opcodes, then pulses `start`. The sequencer decodes one slot at a time, starting with the most significant nibble. Each slot turns into one kind of bus activity:

- a command byte sent with the command latch high;
- one, two or three address bytes sent with the address latch high;
- a wait for the ready/busy line;
- a counted run of data bytes moved between the flash and a small internal byte buffer;
- one or two bytes moved through a 16-bit holding register.

Every byte on the flash side takes exactly one clock cycle, marked by a one-cycle write strobe or read strobe. Read data is captured on the rising edge that ends the read-strobe cycle. The flash strobes cannot be held off: the flash side is modelled as always accepting a byte, and the only source of stalls is the ready/busy wait.

The host fills and inspects the buffer through a plain memory-style port. Host writes are honoured only while the sequencer is idle. When the program ends, `done` rises and stays high until the next start. A reserved opcode ends the program and sets an error flag. A ready wait that runs longer than a programmable number of cycles also ends the program and sets a separate error flag.

Top module: `flash_seq_top`

## Requirements
- R1: Slots run one at a time in order, from the slot in bits 31:28 down to the slot in bits 3:0. Every flash strobe falls inside a busy period, and no other bus activity occurs.
- R2: Opcode 0x0 ends the program at that slot, and the program also ends after the eighth slot. At the end `busy` falls and `done` rises. `done` and both error flags clear when a new start is accepted while idle.
- R3: Opcodes 0x4, 0x5, 0x6 and 0x7 each produce one write-strobe cycle with the command latch high and the address latch low. The byte is command 0, 1, 2 or 3 taken from `cmd_word`, where command 0 sits in bits 31:24, command 1 in 23:16, command 2 in 15:8 and command 3 in 7:0.
- R4: Opcode 0xC and opcode 0xD first wait until `fl_rb` is 1 (ready). After that they send command 0 or command 1 as in R3. No strobe occurs while waiting.
- R5: Opcode 0x1 sends `col_addr` as two bytes, and opcode 0x2 sends `page_addr` as three bytes, both low byte first. Opcode 0x3 sends `user_addr` as one byte. Each address byte takes one write-strobe cycle with the address latch high and the command latch low.
- R6: Opcode 0x8 writes `byte_cnt` bytes, taking byte i from buffer entry i modulo the buffer depth. Opcode 0xA reads `byte_cnt` bytes into buffer entries in the same order. Opcode 0xE waits as in R4 and then does the same as 0xA.
- R7: Opcodes 0x9 and 0xB move one byte, or two bytes when `hold_two` is 1. Opcode 0x9 writes from `hold_wr` and opcode 0xB reads into `hold_rd`, low byte first in both cases.
- R8: A `byte_cnt` of zero makes opcodes 0x8, 0xA and 0xE finish with no data strobe. The following slot then runs.
- R9: Opcode 0xF ends the program and sets `err_ill`, and no later slot runs.
- R10: If `fl_rb` is not seen high within `tmo_lim` cycles of waiting, the program ends with `err_to` set and no command or data strobe.
- R11: A host buffer write while `busy` is high has no effect. A host buffer write while idle updates the entry.
- R12: After reset, `busy`, `done`, `err_ill`, `err_to` and all flash strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts the program when idle |
| instr | input | 32 | Eight packed 4-bit opcodes |
| cmd_word | input | 32 | Four command bytes |
| col_addr | input | 16 | Column address |
| page_addr | input | 24 | Block-plus-page address |
| user_addr | input | 8 | User address byte |
| byte_cnt | input | 12 | Count for counted data steps |
| hold_two | input | 1 | Single-data steps move two bytes |
| hold_wr | input | 16 | Bytes for single-data writes |
| tmo_lim | input | 16 | Ready-wait limit in cycles |
| host_buf_we | input | 1 | Host buffer write enable |
| host_buf_waddr | input | 4 | Host buffer write address |
| host_buf_wdata | input | 8 | Host buffer write data |
| host_buf_raddr | input | 4 | Host buffer read address |
| host_buf_rdata | output | 8 | Host buffer read data |
| fl_cle | output | 1 | Command latch |
| fl_ale | output | 1 | Address latch |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| fl_dout | output | 8 | Byte driven to the flash |
| fl_din | input | 8 | Byte from the flash |
| fl_rb | input | 1 | Ready (1) or busy (0) |
| busy | output | 1 | Program running |
| done | output | 1 | Program finished |
| err_ill | output | 1 | Reserved opcode met |
| err_to | output | 1 | Ready wait timed out |
| hold_rd | output | 16 | Bytes from single-data reads |

## Verification
Each stored program is expanded by a behavioural model into the expected list of strobe cycles, and that list is compared with the strobes the bench records. The programs are chosen to separate specific faults:

- A mixed command-and-address program exposes swapped command fields and address bytes sent high byte first.
- Counted writes and reads show whether the buffer is indexed correctly and whether the byte count is off by one.
- Zero counts and early end opcodes show whether a slot is skipped or run.
- A full eight-slot program tests the stop after the last slot.
- A reserved opcode followed by a valid one shows whether execution stops at the reserved opcode.

Directed runs hold `fl_rb` low, either briefly or past the limit, to tell a real wait from a timeout. A long write program shows that host writes made during the run do not reach the buffer.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_CMD, ST_ADR, ST_WAIT, ST_WR, ST_RD
  } seq_state_t;

  typedef enum logic [1:0] {ASRC_COL, ASRC_PAGE, ASRC_USER} asrc_t;

  localparam logic [OP_W-1:0] OP_END    = 4'h0;
  localparam logic [OP_W-1:0] OP_COL    = 4'h1;
  localparam logic [OP_W-1:0] OP_PAGE   = 4'h2;
  localparam logic [OP_W-1:0] OP_USER   = 4'h3;
  localparam logic [OP_W-1:0] OP_WRBUF  = 4'h8;
  localparam logic [OP_W-1:0] OP_WRHOLD = 4'h9;
  localparam logic [OP_W-1:0] OP_RDBUF  = 4'hA;
  localparam logic [OP_W-1:0] OP_RDHOLD = 4'hB;
  localparam logic [OP_W-1:0] OP_WCMD0  = 4'hC;
  localparam logic [OP_W-1:0] OP_WCMD1  = 4'hD;
  localparam logic [OP_W-1:0] OP_WRD    = 4'hE;
  localparam logic [OP_W-1:0] OP_RSV    = 4'hF;
endpackage

// File: rtl/flash_seq_buf.sv
module flash_seq_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_seq_tmo.sv
module flash_seq_tmo #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] lim,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic [TW:0]   nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + TW'(1);
  end

  assign nxt    = {1'b0, cnt} + (TW+1)'(1);
  assign expire = run && (nxt >= {1'b0, lim});
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CW    = 12,
  parameter int AW    = 4,
  localparam int IW   = SLOTS * OP_W,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic [31:0]   cmd_word,
  input  logic [15:0]   col_addr,
  input  logic [23:0]   page_addr,
  input  logic [7:0]    user_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic          hold_two,
  input  logic [15:0]   hold_wr,
  input  logic          fl_rb,
  input  logic [7:0]    fl_din,
  input  logic          tmo_expire,
  input  logic [7:0]    buf_rdata,
  output logic          tmo_run,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [7:0]    buf_wdata,
  output logic          fl_cle,
  output logic          fl_ale,
  output logic          fl_we,
  output logic          fl_re,
  output logic [7:0]    fl_dout,
  output logic          busy,
  output logic          done,
  output logic          err_ill,
  output logic          err_to,
  output logic [15:0]   hold_rd
);
  seq_state_t      st;
  asrc_t           asrc;
  logic [IW-1:0]   ir;
  logic [SW-1:0]   slot;
  logic [CW-1:0]   idx, last;
  logic [1:0]      csel;
  logic            single, wcmd, adv, slot_last;
  logic [OP_W-1:0] op;

  assign op        = ir[IW-1 -: OP_W];
  assign slot_last = (slot == SW'(SLOTS-1));

  // a step finishes this cycle and the next slot (or the end) follows
  always_comb begin
    case (st)
      ST_DEC:  adv = (op == OP_WRBUF || op == OP_RDBUF) && (byte_cnt == '0);
      ST_CMD:  adv = 1'b1;
      ST_ADR, ST_WR, ST_RD: adv = (idx == last);
      ST_WAIT: adv = fl_rb && !wcmd && (byte_cnt == '0);
      default: adv = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ir <= '0; slot <= '0; idx <= '0; last <= '0;
      csel <= '0; asrc <= ASRC_COL; single <= 1'b0; wcmd <= 1'b0;
      done <= 1'b0; err_ill <= 1'b0; err_to <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (start) begin
        ir <= instr; slot <= '0; done <= 1'b0;
        err_ill <= 1'b0; err_to <= 1'b0; st <= ST_DEC;
      end
    end else if (adv) begin
      ir   <= ir << OP_W;
      slot <= slot + SW'(1);
      idx  <= '0;
      if (slot_last) begin st <= ST_IDLE; done <= 1'b1; end
      else st <= ST_DEC;
    end else begin
      case (st)
        ST_DEC: begin
          idx <= '0;
          case (op)
            OP_END: begin st <= ST_IDLE; done <= 1'b1; end
            OP_RSV: begin st <= ST_IDLE; done <= 1'b1; err_ill <= 1'b1; end
            4'h4, 4'h5, 4'h6, 4'h7: begin csel <= op[1:0]; st <= ST_CMD; end
            OP_WCMD0, OP_WCMD1: begin
              csel <= {1'b0, op[0]}; wcmd <= 1'b1; st <= ST_WAIT;
            end
            OP_WRD:  begin wcmd <= 1'b0; single <= 1'b0; st <= ST_WAIT; end
            OP_COL:  begin asrc <= ASRC_COL;  last <= CW'(1); st <= ST_ADR; end
            OP_PAGE: begin asrc <= ASRC_PAGE; last <= CW'(2); st <= ST_ADR; end
            OP_USER: begin asrc <= ASRC_USER; last <= '0;     st <= ST_ADR; end
            OP_WRBUF: begin single <= 1'b0; last <= byte_cnt - CW'(1); st <= ST_WR; end
            OP_RDBUF: begin single <= 1'b0; last <= byte_cnt - CW'(1); st <= ST_RD; end
            OP_WRHOLD: begin single <= 1'b1; last <= CW'(hold_two); st <= ST_WR; end
            OP_RDHOLD: begin single <= 1'b1; last <= CW'(hold_two); st <= ST_RD; end
            default: ;
          endcase
        end
        ST_WAIT: begin
          if (fl_rb) begin
            if (wcmd) st <= ST_CMD;
            else begin last <= byte_cnt - CW'(1); st <= ST_RD; end
          end else if (tmo_expire) begin
            st <= ST_IDLE; done <= 1'b1; err_to <= 1'b1;
          end
        end
        ST_ADR, ST_WR, ST_RD: idx <= idx + CW'(1);
        default: ;
      endcase
    end
  end

  // single-data read capture runs beside the step control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_rd <= '0;
    else if (st == ST_RD && single) hold_rd[{idx[0], 3'b000} +: 8] <= fl_din;
  end

  always_comb begin
    case (st)
      ST_CMD: fl_dout = cmd_word[{~csel, 3'b000} +: 8];
      ST_ADR: begin
        case (asrc)
          ASRC_COL:  fl_dout = col_addr[{idx[0], 3'b000} +: 8];
          ASRC_PAGE: fl_dout = page_addr[{idx[1:0], 3'b000} +: 8];
          default:   fl_dout = user_addr;
        endcase
      end
      ST_WR:   fl_dout = single ? hold_wr[{idx[0], 3'b000} +: 8] : buf_rdata;
      default: fl_dout = 8'h00;
    endcase
  end

  assign fl_cle    = (st == ST_CMD);
  assign fl_ale    = (st == ST_ADR);
  assign fl_we     = (st == ST_CMD) || (st == ST_ADR) || (st == ST_WR);
  assign fl_re     = (st == ST_RD);
  assign busy      = (st != ST_IDLE);
  assign tmo_run   = (st == ST_WAIT) && !fl_rb;
  assign buf_addr  = idx[AW-1:0];
  assign buf_we    = (st == ST_RD) && !single;
  assign buf_wdata = fl_din;
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top #(
  parameter int SLOTS     = 8,
  parameter int CNT_W     = 12,
  parameter int BUF_DEPTH = 16,
  parameter int TMO_W     = 16,
  localparam int IW = SLOTS * flash_seq_pkg::OP_W,
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    instr,
  input  logic [31:0]      cmd_word,
  input  logic [15:0]      col_addr,
  input  logic [23:0]      page_addr,
  input  logic [7:0]       user_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             hold_two,
  input  logic [15:0]      hold_wr,
  input  logic [TMO_W-1:0] tmo_lim,
  input  logic             host_buf_we,
  input  logic [AW-1:0]    host_buf_waddr,
  input  logic [7:0]       host_buf_wdata,
  input  logic [AW-1:0]    host_buf_raddr,
  output logic [7:0]       host_buf_rdata,
  output logic             fl_cle,
  output logic             fl_ale,
  output logic             fl_we,
  output logic             fl_re,
  output logic [7:0]       fl_dout,
  input  logic [7:0]       fl_din,
  input  logic             fl_rb,
  output logic             busy,
  output logic             done,
  output logic             err_ill,
  output logic             err_to,
  output logic [15:0]      hold_rd
);
  logic          tmo_run, tmo_expire, seq_we, mem_we;
  logic [AW-1:0] seq_addr, mem_waddr;
  logic [7:0]    seq_wdata, seq_rdata, mem_wdata;

  // the sequencer owns the buffer while running; host writes need idle
  assign mem_we    = seq_we || (host_buf_we && !busy);
  assign mem_waddr = seq_we ? seq_addr  : host_buf_waddr;
  assign mem_wdata = seq_we ? seq_wdata : host_buf_wdata;

  flash_seq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(seq_addr), .rdata_a(seq_rdata),
    .raddr_b(host_buf_raddr), .rdata_b(host_buf_rdata)
  );

  flash_seq_tmo #(.TW(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmo_run), .lim(tmo_lim), .expire(tmo_expire)
  );

  flash_seq_ctrl #(.SLOTS(SLOTS), .CW(CNT_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .cmd_word(cmd_word), .col_addr(col_addr), .page_addr(page_addr),
    .user_addr(user_addr), .byte_cnt(byte_cnt), .hold_two(hold_two),
    .hold_wr(hold_wr), .fl_rb(fl_rb), .fl_din(fl_din),
    .tmo_expire(tmo_expire), .buf_rdata(seq_rdata), .tmo_run(tmo_run),
    .buf_addr(seq_addr), .buf_we(seq_we), .buf_wdata(seq_wdata),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we), .fl_re(fl_re),
    .fl_dout(fl_dout), .busy(busy), .done(done), .err_ill(err_ill),
    .err_to(err_to), .hold_rd(hold_rd)
  );
endmodule

// File: rtl/flash_seq_sva.sv
module flash_seq_sva (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err_ill,
  input logic err_to,
  input logic fl_cle,
  input logic fl_ale,
  input logic fl_we,
  input logic fl_re
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_cle && fl_ale)); // R5

  AST_CMD_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cle |-> (fl_we && !fl_re)); // R3

  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> busy); // R1

  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !err_ill && !err_to)); // R2

  AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ill || err_to) |-> done); // R9
endmodule

bind flash_seq_top flash_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_ill(err_ill), .err_to(err_to), .fl_cle(fl_cle), .fl_ale(fl_ale),
  .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/flash_seq_top_tb.sv
module flash_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [31:0] ins;
    logic [11:0] cnt;
    logic        two;
    logic [7:0]  nev;
    logic        ill;
  } vec_t;

  // program, count, two-byte flag, expected strobe cycles, expected illegal
  localparam vec_t VEC [NVEC] = '{
    '{32'h4125_0000, 12'd0, 1'b0, 8'd7, 1'b0},
    '{32'h6783_0000, 12'd3, 1'b0, 8'd6, 1'b0},
    '{32'hCA00_0000, 12'd4, 1'b0, 8'd5, 1'b0},
    '{32'h9B00_0000, 12'd0, 1'b1, 8'd4, 1'b0},
    '{32'h8A8D_0000, 12'd0, 1'b0, 8'd1, 1'b0},
    '{32'h4F50_0000, 12'd0, 1'b0, 8'd1, 1'b1},
    '{32'h4444_4444, 12'd0, 1'b0, 8'd8, 1'b0},
    '{32'hE900_0000, 12'd2, 1'b0, 8'd3, 1'b0},
    '{32'h0400_0000, 12'd0, 1'b0, 8'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] cmd_word = 32'h1122_3344;
  logic [15:0] col_addr = 16'h3412;
  logic [23:0] page_addr = 24'h675645;
  logic [7:0]  user_addr = 8'h9A;
  logic [11:0] byte_cnt = '0;
  logic        hold_two = 1'b0;
  logic [15:0] hold_wr = 16'hBBAA;
  logic [15:0] tmo_lim = 16'd50;
  logic        host_buf_we = 1'b0;
  logic [3:0]  host_buf_waddr = '0, host_buf_raddr = '0;
  logic [7:0]  host_buf_wdata = '0, host_buf_rdata;
  logic fl_cle, fl_ale, fl_we, fl_re, fl_rb = 1'b1;
  logic [7:0] fl_dout, fl_din;
  logic busy, done, err_ill, err_to;
  logic [15:0] hold_rd;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int nact = 0, rd_seen = 0, rb_low_strobes = 0, nexp = 0;
  logic mon_on = 1'b0;
  logic [11:0] act_ev [64];
  logic [11:0] exp_ev [64];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign fl_din = 8'h50 + 8'(rd_seen);

  flash_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .cmd_word(cmd_word), .col_addr(col_addr), .page_addr(page_addr),
    .user_addr(user_addr), .byte_cnt(byte_cnt), .hold_two(hold_two),
    .hold_wr(hold_wr), .tmo_lim(tmo_lim), .host_buf_we(host_buf_we),
    .host_buf_waddr(host_buf_waddr), .host_buf_wdata(host_buf_wdata),
    .host_buf_raddr(host_buf_raddr), .host_buf_rdata(host_buf_rdata),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we), .fl_re(fl_re),
    .fl_dout(fl_dout), .fl_din(fl_din), .fl_rb(fl_rb), .busy(busy),
    .done(done), .err_ill(err_ill), .err_to(err_to), .hold_rd(hold_rd)
  );

  // flash-side recorder, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_on && (fl_we || fl_re)) begin
      if (nact < 64) act_ev[nact] = {fl_cle, fl_ale, fl_we, fl_re, fl_dout};
      nact++;
      if (!fl_rb) rb_low_strobes++;
      if (fl_re) rd_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] kind, input logic [7:0] b);
    exp_ev[nexp] = {kind, b};
    nexp++;
  endtask

  // reference expansion of a program into strobe cycles {cle,ale,we,re,byte}
  task automatic build(input logic [31:0] ins, input int cnt, input logic two);
    logic [7:0] cmdb [4];
    cmdb[0] = 8'h11; cmdb[1] = 8'h22; cmdb[2] = 8'h33; cmdb[3] = 8'h44;
    nexp = 0;
    for (int s = 0; s < 8; s++) begin
      logic [3:0] op;
      op = ins[31 - 4*s -: 4];
      if (op == 4'h0 || op == 4'hF) break;
      case (op)
        4'h4, 4'h5, 4'h6, 4'h7: push(4'b1010, cmdb[op - 4'h4]);
        4'hC: push(4'b1010, cmdb[0]);
        4'hD: push(4'b1010, cmdb[1]);
        4'h1: begin push(4'b0110, 8'h12); push(4'b0110, 8'h34); end
        4'h2: begin push(4'b0110, 8'h45); push(4'b0110, 8'h56); push(4'b0110, 8'h67); end
        4'h3: push(4'b0110, 8'h9A);
        4'h8: for (int i = 0; i < cnt; i++) push(4'b0010, 8'hA0 + 8'(i % 16));
        4'h9: begin push(4'b0010, 8'hAA); if (two) push(4'b0010, 8'hBB); end
        4'hA, 4'hE: for (int i = 0; i < cnt; i++) push(4'b0001, 8'h00);
        4'hB: begin push(4'b0001, 8'h00); if (two) push(4'b0001, 8'h00); end
        default: ;
      endcase
    end
  endtask

  task automatic fill_buf();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      host_buf_we = 1'b1; host_buf_waddr = 4'(i); host_buf_wdata = 8'hA0 + 8'(i);
    end
    @(negedge clk);
    host_buf_we = 1'b0;
  endtask

  task automatic rd_buf(input int a, output logic [7:0] v);
    host_buf_raddr = 4'(a);
    #1;
    v = host_buf_rdata;
  endtask

  task automatic run(input logic [31:0] ins, input logic [11:0] cnt,
                     input logic two, output int cycles);
    @(negedge clk);
    instr = ins; byte_cnt = cnt; hold_two = two;
    nact = 0; rd_seen = 0; rb_low_strobes = 0; mon_on = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (busy && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
    mon_on = 1'b0;
  endtask

  function automatic string tag_of(input int v);
    case (v)
      0: return "R5";
      1: return "R3";
      2: return "R4";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      6: return "R2";
      7: return "R6";
      default: return "R1";
    endcase
  endfunction

  initial begin
    int cycles;
    logic [7:0] b;

    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 busy", 32'(busy), 32'd0);
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 errors", {30'd0, err_ill, err_to}, 32'd0);
    chk("R12 strobes", {28'd0, fl_cle, fl_ale, fl_we, fl_re}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      fill_buf();
      build(VEC[v].ins, int'(VEC[v].cnt), VEC[v].two);
      run(VEC[v].ins, VEC[v].cnt, VEC[v].two, cycles);
      chk({tag_of(v), " R1 strobe count"}, 32'(nact), 32'(VEC[v].nev));
      chk({tag_of(v), " model count"}, 32'(nexp), 32'(VEC[v].nev));
      for (int i = 0; i < nexp && i < nact; i++)
        chk({tag_of(v), " strobe cycle"}, 32'(act_ev[i]), 32'(exp_ev[i]));
      chk("R2 done at end", 32'(done), 32'd1);
      chk("R9 illegal flag", 32'(err_ill), 32'(VEC[v].ill));
      chk("R10 no timeout", 32'(err_to), 32'd0);
      if (v == 2) for (int i = 0; i < 4; i++) begin
        rd_buf(i, b);
        chk("R6 counted read into buffer", 32'(b), 32'h51 + 32'(i));
      end
      if (v == 3) chk("R7 hold read bytes", 32'(hold_rd), 32'h5251);
      if (v == 7) for (int i = 0; i < 2; i++) begin
        rd_buf(i, b);
        chk("R6 wait then read", 32'(b), 32'h51 + 32'(i));
      end
    end

    // R10: ready never seen
    fl_rb = 1'b0; tmo_lim = 16'd5;
    run(32'hC000_0000, 12'd0, 1'b0, cycles);
    chk("R10 timeout flag", 32'(err_to), 32'd1);
    chk("R10 done", 32'(done), 32'd1);
    chk("R10 no strobe", 32'(nact), 32'd0);
    chk("R10 wait length", 32'(cycles >= 5 && cycles <= 9), 32'd1);

    // R4: ready arrives late
    tmo_lim = 16'd100;
    fork
      run(32'hC000_0000, 12'd0, 1'b0, cycles);
      begin repeat (7) @(negedge clk); fl_rb = 1'b1; end
    join
    chk("R4 late ready no timeout", 32'(err_to), 32'd0);
    chk("R4 one strobe", 32'(nact), 32'd1);
    chk("R4 command 0 after ready", 32'(act_ev[0]), 32'h A11);
    chk("R4 no strobe while busy line low", 32'(rb_low_strobes), 32'd0);
    chk("R4 waited", 32'(cycles >= 6), 32'd1);

    // R11 with R6 wrap: host write during run ignored
    fill_buf();
    fork
      run(32'h8000_0000, 12'd40, 1'b0, cycles);
      begin
        repeat (6) @(negedge clk);
        host_buf_we = 1'b1; host_buf_waddr = 4'd3; host_buf_wdata = 8'h77;
        @(negedge clk);
        host_buf_we = 1'b0;
      end
    join
    chk("R6 long write count", 32'(nact), 32'd40);
    chk("R6 index wraps", 32'(act_ev[39]), 32'h2A7);
    rd_buf(3, b);
    chk("R11 busy write ignored", 32'(b), 32'hA3);
    @(negedge clk);
    host_buf_we = 1'b1; host_buf_waddr = 4'd3; host_buf_wdata = 8'h77;
    @(negedge clk);
    host_buf_we = 1'b0;
    rd_buf(3, b);
    chk("R11 idle write lands", 32'(b), 32'h77);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule